// File: doc/BRIEF.md
# Embedded Sync Timing Extractor

This block sits at the front of a video input path that receives multiplexed YCbCr 4:2:2 on a single bus, where the interface clock runs at twice the pixel rate and the components arrive one per clock. The stream has no sync pins. Its timing travels inside the data as four-word reference codes: a word of all ones, two zero words, then a status word. The block finds these codes and rebuilds horizontal sync, vertical sync, a field flag and a data-enable that marks the active payload.

The bus width can be 8, 10 or 12 bits and is chosen at run time. The incoming word is masked to the selected width and passed through a four-stage delay line. The rebuilt controls line up with the word currently on the output. The status word carries three flags just below its most significant bit, at MSB-1, MSB-2 and MSB-3: field, vertical blanking and an end/start marker. A start code opens an active span unless vertical blanking is flagged. An end code closes the span, starts the horizontal sync pulse and loads the vertical and field flags. The source must keep every active span an even number of clocks long and every line longer than the sync pulse.

Top module: `embsync_extract`

## Requirements
- R1: While rst_n is low, dout is zero and de, hsync, vsync and field are low.
- R2: A word sampled on rising edge n is presented on dout, masked to the selected width, from edge n+3 until edge n+4.
- R3: Only the low bits of the selected width take part in code detection and reach dout; the bits above are ignored, and dout carries zeros there. The all-ones and zero code words are judged at the selected width. The status word holds F at bit MSB-1, V at bit MSB-2 and H at bit MSB-3, where MSB is the top bit of the selected width.
- R4: de is high exactly for the dout words that lie between a start code (H=0) with V=0 and the next end code (H=1). The four words of any code are never marked active.
- R5: A start code with V=1 opens no active span, so de stays low for the whole line.
- R6: hsync is high for exactly HS_CLKS clocks. The pulse begins in the clock when the first word of an end code is on dout, which is the same clock in which de falls.
- R7: vsync takes the V bit of each end code. It changes in the clock when the end code's first word reaches dout and holds until the next end code.
- R8: field takes the F bit of each end code, with the same timing as vsync.
- R9: width_sel encodes the bus width as 0 for 8 bits, 1 for 10 bits, and 2 or 3 for 12 bits.
- R10: In 12-bit mode, a sequence of 0x0FF, 0x000, 0x000 followed by a status-like word is not a code. It is carried as ordinary data and leaves de, hsync, vsync and field unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock at twice the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| width_sel | input | 2 | Bus width select (0: 8, 1: 10, 2/3: 12 bits) |
| din | input | 12 | Incoming multiplexed word, LSB aligned |
| dout | output | 12 | Masked word delayed through four registers |
| de | output | 1 | Active payload marker aligned with dout |
| hsync | output | 1 | Regenerated horizontal sync pulse |
| vsync | output | 1 | Vertical blanking flag from the last end code |
| field | output | 1 | Field flag from the last end code |

## Verification
The bench concentrates on the clocks next to the codes. It checks that the first payload word after a start code is the first word marked by de. A design off by one stage there would flag the status word or drop a pixel. It also checks that de falls on the first all-ones word of the end code, where a design that reacts only at the status word would leave three code words marked active. Separate tests cover each width, junk above an 8-bit bus, a blanking line that must stay dark, and a 12-bit payload that looks like an 8-bit code. A design that masks wrongly, or places the flag bits wrongly, would then raise false syncs or miss real ones.

// File: rtl/embsync_pkg.sv
package embsync_pkg;

   localparam int BUS_W    = 12;
   localparam int CODE_LEN = 4;

   typedef enum logic [1:0] {
      BW_8   = 2'd0,
      BW_10  = 2'd1,
      BW_12  = 2'd2,
      BW_12X = 2'd3
   } bw_e;

   typedef struct packed {
      logic sav;
      logic eav;
      logic f;
      logic v;
   } code_t;

   function automatic int bw_bits(input logic [1:0] sel);
      case (bw_e'(sel))
         BW_8:    return 8;
         BW_10:   return 10;
         default: return 12;
      endcase
   endfunction

   function automatic logic [BUS_W-1:0] bw_mask(input logic [1:0] sel);
      logic [BUS_W-1:0] m;
      int n;
      n = bw_bits(sel);
      for (int i = 0; i < BUS_W; i++) m[i] = (i < n);
      return m;
   endfunction

endpackage

// File: rtl/embsync_pipe.sv
module embsync_pipe #(
   parameter int W     = 12,
   parameter int DEPTH = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [W-1:0]              d,
   output logic [DEPTH-1:0][W-1:0]   taps
);

   logic [W-1:0] st [DEPTH];

   if (DEPTH < 2) begin : g_bad_depth
      $error("embsync_pipe: DEPTH must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) st[i] <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < DEPTH; i++) st[i] <= st[i-1];
      end
   end

   for (genvar s = 0; s < DEPTH; s++) begin : g_tap
      assign taps[s] = st[s];
   end

endmodule

// File: rtl/embsync_code_det.sv
module embsync_code_det
   import embsync_pkg::*;
(
   input  logic [1:0]             width_sel,
   input  logic [BUS_W-1:0]       cur,
   input  logic [2:0][BUS_W-1:0]  hist,
   output code_t                  code
);

   logic [BUS_W-1:0] ones;
   logic             lead_ok;
   logic             f_b, v_b, h_b;

   always_comb begin
      ones    = bw_mask(width_sel);
      lead_ok = (hist[2] == ones) && (hist[1] == '0) && (hist[0] == '0);
      case (bw_e'(width_sel))
         BW_8: begin
            f_b = cur[6]; v_b = cur[5]; h_b = cur[4];
         end
         BW_10: begin
            f_b = cur[8]; v_b = cur[7]; h_b = cur[6];
         end
         default: begin
            f_b = cur[10]; v_b = cur[9]; h_b = cur[8];
         end
      endcase
      code.sav = lead_ok && !h_b;
      code.eav = lead_ok && h_b;
      code.f   = f_b;
      code.v   = v_b;
   end

endmodule

// File: rtl/embsync_timing.sv
module embsync_timing
   import embsync_pkg::*;
#(
   parameter int HS_CLKS = 16,
   parameter int DEPTH   = 4
) (
   input  logic   clk,
   input  logic   rst_n,
   input  code_t  code,
   output logic   de,
   output logic   hsync,
   output logic   vsync,
   output logic   field
);

   localparam int CNT_W = $clog2(HS_CLKS + 1);

   logic [DEPTH-1:0] act;
   logic             span_open;
   logic [CNT_W-1:0] hs_cnt;

   if (HS_CLKS < 1) begin : g_bad_hs
      $error("embsync_timing: HS_CLKS must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act       <= '0;
         span_open <= 1'b0;
         hs_cnt    <= '0;
         vsync     <= 1'b0;
         field     <= 1'b0;
      end else begin
         if (code.sav || code.eav) act <= '0;
         else                      act <= {act[DEPTH-2:0], span_open};

         if (code.eav) begin
            span_open <= 1'b0;
            hs_cnt    <= CNT_W'(HS_CLKS);
            vsync     <= code.v;
            field     <= code.f;
         end else begin
            if (code.sav) span_open <= !code.v;
            if (hs_cnt != '0) hs_cnt <= hs_cnt - 1'b1;
         end
      end
   end

   assign de    = act[DEPTH-1];
   assign hsync = (hs_cnt != '0);

endmodule

// File: rtl/embsync_extract.sv
module embsync_extract
   import embsync_pkg::*;
#(
   parameter int HS_CLKS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        width_sel,
   input  logic [BUS_W-1:0]  din,
   output logic [BUS_W-1:0]  dout,
   output logic              de,
   output logic              hsync,
   output logic              vsync,
   output logic              field
);

   logic [BUS_W-1:0]                din_m;
   logic [CODE_LEN-1:0][BUS_W-1:0]  taps;
   code_t                           code_w;
   logic                            sav_hit, eav_hit;

   if (CODE_LEN != 4) begin : g_bad_code
      $error("embsync_extract: code length must be four words");
   end

   assign din_m = din & bw_mask(width_sel);

   embsync_pipe #(.W(BUS_W), .DEPTH(CODE_LEN)) u_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (din_m),
      .taps  (taps)
   );

   embsync_code_det u_det (
      .width_sel (width_sel),
      .cur       (din_m),
      .hist      (taps[2:0]),
      .code      (code_w)
   );

   embsync_timing #(.HS_CLKS(HS_CLKS), .DEPTH(CODE_LEN)) u_tim (
      .clk   (clk),
      .rst_n (rst_n),
      .code  (code_w),
      .de    (de),
      .hsync (hsync),
      .vsync (vsync),
      .field (field)
   );

   assign dout    = taps[CODE_LEN-1];
   assign sav_hit = code_w.sav;
   assign eav_hit = code_w.eav;

endmodule

// File: rtl/embsync_extract_chk.sv
module embsync_extract_chk #(
   parameter int HS_CLKS = 16
) (
   input logic        clk,
   input logic        rst_n,
   input logic [1:0]  width_sel,
   input logic [11:0] dout,
   input logic        de,
   input logic        hsync,
   input logic        vsync,
   input logic        field,
   input logic        sav_hit,
   input logic        eav_hit
);

   int unsigned hs_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hs_run <= 0;
      else if (hsync)  hs_run <= hs_run + 1;
      else             hs_run <= 0;
   end

   a_r4_de_fall_on_eav: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(de) |-> $past(eav_hit));

   a_r4_de_rise_after_sav: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(de) |-> $past(sav_hit, 5));

   a_r6_hs_start_de_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hsync) |-> !de);

   a_r6_hs_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hsync) |-> (hs_run == HS_CLKS));

   a_r7_vs_on_eav: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(vsync) |-> $past(eav_hit));

   a_r8_fld_on_eav: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(field) |-> $past(eav_hit));

   a_r3_mask_8bit: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(width_sel, 4) == 2'd0) |-> (dout[11:8] == 4'h0));

endmodule

bind embsync_extract embsync_extract_chk #(.HS_CLKS(HS_CLKS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .width_sel (width_sel),
   .dout      (dout),
   .de        (de),
   .hsync     (hsync),
   .vsync     (vsync),
   .field     (field),
   .sav_hit   (sav_hit),
   .eav_hit   (eav_hit)
);

// File: tb/tb_embsync_extract.sv
module tb_embsync_extract;

   localparam int HS = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  width_sel = 2'd0;
   logic [11:0] din = '0;
   logic [11:0] dout;
   logic        de, hsync, vsync, field;

   int n_chk = 0;
   int n_fail = 0;
   string scen = "R1 reset";

   logic [11:0] e_d  [8];
   logic        e_de [8];
   logic        e_hs [8];
   logic        e_vs [8];
   logic        e_fl [8];
   int          widx = 0;
   int          hs_left = 0;
   logic        m_v = 1'b0;
   logic        m_f = 1'b0;
   logic [11:0] junk = '0;

   always #2 clk = ~clk;

   embsync_extract #(.HS_CLKS(HS)) dut (
      .clk(clk), .rst_n(rst_n), .width_sel(width_sel), .din(din),
      .dout(dout), .de(de), .hsync(hsync), .vsync(vsync), .field(field)
   );

   function automatic logic [11:0] tmask(input logic [1:0] sel);
      case (sel)
         2'd0:    return 12'h0FF;
         2'd1:    return 12'h3FF;
         default: return 12'hFFF;
      endcase
   endfunction

   function automatic int tbits(input logic [1:0] sel);
      case (sel)
         2'd0:    return 8;
         2'd1:    return 10;
         default: return 12;
      endcase
   endfunction

   function automatic logic [11:0] status(input logic f, input logic v, input logic h);
      logic [11:0] s;
      int b;
      b = tbits(width_sel);
      s = '0;
      s[b-1] = 1'b1;
      s[b-2] = f;
      s[b-3] = v;
      s[b-4] = h;
      return s;
   endfunction

   task automatic chk(input string tag, input logic [11:0] got, input logic [11:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL [%s] %s: got %h expected %h", scen, tag, got, exp);
      end
   endtask

   // drive one word, then check the word that left the pipe (R2, R4, R6, R7, R8)
   task automatic emit(input logic [11:0] w, input logic act, input logic eav0,
                       input logic v, input logic f);
      int i;
      int j;
      logic [11:0] mk;
      mk = tmask(width_sel);
      din = w | (junk & ~mk);
      if (eav0) begin
         hs_left = HS;
         m_v = v;
         m_f = f;
      end
      i = widx & 7;
      e_d[i]  = w & mk;
      e_de[i] = act;
      e_hs[i] = (hs_left > 0);
      if (hs_left > 0) hs_left--;
      e_vs[i] = m_v;
      e_fl[i] = m_f;
      @(negedge clk);
      if (widx >= 3) begin
         j = (widx - 3) & 7;
         chk("R2 dout",   dout,          e_d[j]);
         chk("R4 de",     {11'd0, de},    {11'd0, e_de[j]});
         chk("R6 hsync",  {11'd0, hsync}, {11'd0, e_hs[j]});
         chk("R7 vsync",  {11'd0, vsync}, {11'd0, e_vs[j]});
         chk("R8 field",  {11'd0, field}, {11'd0, e_fl[j]});
      end
      widx++;
   endtask

   task automatic code4(input logic f, input logic v, input logic h);
      emit(tmask(width_sel), 1'b0, h, v, f);
      emit(12'h000, 1'b0, 1'b0, v, f);
      emit(12'h000, 1'b0, 1'b0, v, f);
      emit(status(f, v, h), 1'b0, 1'b0, v, f);
   endtask

   task automatic line(input logic f, input logic v, input int nblank,
                       input int nact, input logic fake);
      int mk;
      mk = int'(tmask(width_sel));
      code4(f, v, 1'b1);
      for (int b = 0; b < nblank; b++) emit(12'h155 & tmask(width_sel), 1'b0, 1'b0, v, f);
      code4(f, v, 1'b0);
      for (int a = 0; a < nact; a++) begin
         if (fake && a == nact / 2) begin
            emit(12'h0FF, !v, 1'b0, v, f);
            emit(12'h000, !v, 1'b0, v, f);
            emit(12'h000, !v, 1'b0, v, f);
            emit(12'h2C0, !v, 1'b0, v, f);
         end
         emit(12'(($urandom % (mk - 1)) + 1), !v, 1'b0, v, f);
      end
   endtask

   task automatic tail(input logic f);
      code4(f, 1'b0, 1'b1);
      for (int b = 0; b < 8; b++) emit(12'h155 & tmask(width_sel), 1'b0, 1'b0, 1'b0, f);
   endtask

   task automatic t_reset;
      scen = "R1 reset";
      rst_n = 1'b0;
      din = 12'hFFF;
      repeat (5) @(negedge clk);
      chk("R1 dout", dout, 12'h000);
      chk("R1 de",    {11'd0, de},    12'd0);
      chk("R1 hsync", {11'd0, hsync}, 12'd0);
      chk("R1 vsync", {11'd0, vsync}, 12'd0);
      chk("R1 field", {11'd0, field}, 12'd0);
      rst_n = 1'b1;
   endtask

   task automatic t_width(input logic [1:0] sel, input string name);
      scen = name;
      width_sel = sel;
      line(1'b0, 1'b0, 4, 8, 1'b0);
      line(1'b0, 1'b0, 6, 10, 1'b0);
      tail(1'b0);
   endtask

   task automatic t_vblank;
      scen = "R5 R7 vertical blanking lines";
      width_sel = 2'd2;
      line(1'b0, 1'b1, 4, 8, 1'b0);
      line(1'b0, 1'b1, 4, 8, 1'b0);
      line(1'b0, 1'b0, 4, 8, 1'b0);
      tail(1'b0);
   endtask

   task automatic t_field;
      scen = "R8 second field";
      width_sel = 2'd1;
      line(1'b1, 1'b0, 4, 6, 1'b0);
      line(1'b1, 1'b1, 4, 6, 1'b0);
      line(1'b0, 1'b0, 4, 6, 1'b0);
      tail(1'b0);
   endtask

   task automatic t_junk;
      scen = "R3 8-bit with junk above the bus";
      width_sel = 2'd0;
      junk = 12'hA50;
      line(1'b1, 1'b0, 4, 8, 1'b0);
      line(1'b0, 1'b0, 4, 8, 1'b0);
      tail(1'b0);
      junk = 12'h000;
   endtask

   task automatic t_fake;
      scen = "R10 12-bit narrow look-alike code";
      width_sel = 2'd2;
      line(1'b0, 1'b0, 4, 8, 1'b1);
      tail(1'b0);
   endtask

   initial begin
      t_reset();
      t_width(2'd0, "R9 R3 8-bit lines");
      t_width(2'd1, "R9 R3 10-bit lines");
      t_width(2'd2, "R9 R3 12-bit lines");
      t_vblank();
      t_field();
      t_junk();
      t_fake();
      t_width(2'd3, "R9 select 3 as 12-bit");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #400000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule